// File: doc/BRIEF.md
# Multi-Mode Serial Transmitter

This block turns a written data word into a serial bit stream on a single transmit line. A 3-bit mode code selects the format. The asynchronous formats carry 7, 8 or 9 data bits in a start/stop frame, with optional parity and one or two stop bits. The clock-synchronous format shifts 8 bits next to a transfer clock. One shift register serves every format. Bit timing comes from a one-cycle `bit_tick` strobe that a baud generator outside the block supplies.

A write to the data port fills a one-entry holding buffer. A frame is loaded from that buffer when the line is free and flow control allows it. A second write made during a frame waits in the buffer and starts as soon as the current frame ends. The `tx_empty` flag is high only when nothing is being shifted and nothing is waiting. In synchronous mode the transfer clock is either generated from the tick or taken from an external clock pin. A polarity bit chooses which clock edge moves the data. A line-inversion bit inverts the transmit output in every mode.

Top module: `sio_tx`

## Requirements
- R1: Mode codes are 001 (synchronous), 100 (async 7-bit), 101 (async 8-bit) and 110 (async 9-bit). Any other code, 000 included, aborts a running frame and discards the buffer. While such a code is set, writes are ignored, `tx_empty` reads 1 one cycle later and the line stays idle.
- R2: An async frame is sent in this order: a start bit (0), the data bits, the parity bit if enabled, then the stop bit(s) (1). The idle line level is 1 before inversion.
- R3: The async data width is 7 (`wr_data[6:0]`), 8 (`wr_data[7:0]`) or 9 (`wr_data[8:0]`) bits, as the mode selects.
- R4: When `par_en`=1, one parity bit follows the data. With `par_even`=0 it makes the count of ones in data plus parity odd; with `par_even`=1 it makes that count even.
- R5: `stop2`=0 sends one stop bit and `stop2`=1 sends two.
- R6: When `inv_line`=1, `txd` is the inverse of the frame bit, and the idle level is also inverted.
- R7: `msb_first`=1 sends data MSB first in synchronous mode and in async 8-bit mode. The 7-bit and 9-bit async modes always send LSB first.
- R8: In synchronous mode with the internal clock (`clk_ext`=0), each bit takes two ticks. The first tick moves `sclk_out` to its active level (equal to `clk_pol`) and drives the next bit on `txd`. The second tick returns `sclk_out` to its idle level (`!clk_pol`). So data changes on the falling edge when `clk_pol`=0 and on the rising edge when `clk_pol`=1. Eight bits are sent per frame.
- R9: In synchronous mode with `clk_ext`=1, data moves on the driving edge of `ext_clk` (falling when `clk_pol`=0, rising when `clk_pol`=1), after a two-flop synchronizer. The frame ends at the eighth opposite edge. `sclk_out` holds its idle level.
- R10: `tx_empty` resets to 1. It reads 0 from the cycle after a write until the last frame bit has been shifted out and no buffered data remains.
- R11: When `flow_off`=0 and `rts_sel`=0, a frame may start only while `cts_n`=0. A frame already running is not stopped. When either bit is 1, `cts_n` is ignored.
- R12: A write made while a frame is running is held. It starts on the same tick that ends the current async frame, so the line does not go idle between the two frames.
- R13: In async mode, a buffered frame starts on the first `bit_tick` after the write, and each later tick advances the line by one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit timing strobe |
| mode | input | 3 | Operating mode code |
| stop2 | input | 1 | Two stop bits when 1 |
| par_en | input | 1 | Parity enable |
| par_even | input | 1 | Even parity when 1, odd when 0 |
| inv_line | input | 1 | Invert the transmit line |
| clk_ext | input | 1 | Synchronous mode uses `ext_clk` when 1 |
| clk_pol | input | 1 | Transfer clock polarity |
| msb_first | input | 1 | MSB-first order where allowed |
| flow_off | input | 1 | Disables flow control when 1 |
| rts_sel | input | 1 | Selects the request function instead of clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| ext_clk | input | 1 | External transfer clock |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 9 | Data word to send |
| txd | output | 1 | Serial transmit line |
| sclk_out | output | 1 | Generated transfer clock |
| tx_empty | output | 1 | No frame running and buffer empty |

## Verification
The hardest case to reach is the async handover, where a buffered word must begin on exactly the tick that retires the previous frame's last stop bit. The stimulus writes one word, lets its start bit go out, writes a second word, and then checks every tick through the boundary. At the boundary the line must show the new start bit, not an idle cell. Clear-to-send gating is reached by holding `cts_n` high with a word buffered for several ticks, then releasing it. Randomized frames cover every mix of width, parity, stop count, inversion and bit order, plus both synchronous clock sources.

// File: rtl/sio_tx.sv
module sio_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic [2:0] mode,
  input  logic       stop2,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       inv_line,
  input  logic       clk_ext,
  input  logic       clk_pol,
  input  logic       msb_first,
  input  logic       flow_off,
  input  logic       rts_sel,
  input  logic       cts_n,
  input  logic       ext_clk,
  input  logic       wr_en,
  input  logic [8:0] wr_data,
  output logic       txd,
  output logic       sclk_out,
  output logic       tx_empty
);
  localparam int FW = 13;

  logic          active, buf_full, sync_f, r;
  logic [8:0]    hold;
  logic [FW-1:0] sh;
  logic [3:0]    cnt;
  logic [2:0]    ext_s;

  logic [8:0]    dsel;
  logic [3:0]    nd, alen;
  logic [FW-1:0] afrm;
  logic          par_bit;

  wire legal   = mode inside {3'b001, 3'b100, 3'b101, 3'b110};
  wire is_sync = (mode == 3'b001);
  wire go_ok   = buf_full && (flow_off || rts_sel || !cts_n);

  wire ext_rise = ext_s[1] & ~ext_s[2];
  wire ext_fall = ~ext_s[1] & ext_s[2];
  wire drv = clk_ext ? (clk_pol ? ext_rise : ext_fall) : (bit_tick & r);
  wire smp = clk_ext ? (clk_pol ? ext_fall : ext_rise) : (bit_tick & ~r);

  wire step_a = active && !sync_f && bit_tick;
  wire end_a  = step_a && (cnt == 4'd1);
  wire start  = is_sync ? (drv && !active && go_ok)
                        : (bit_tick && go_ok && (!active || end_a));

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  always_comb begin
    case (mode)
      3'b100:  dsel = {2'b00, hold[6:0]};
      3'b110:  dsel = hold;
      default: dsel = {1'b0, msb_first ? rev8(hold[7:0]) : hold[7:0]};
    endcase
    nd = (mode == 3'b100) ? 4'd7 : (mode == 3'b110) ? 4'd9 : 4'd8;
    par_bit = par_even ? ^dsel : ~^dsel;
    afrm = '1;
    afrm[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < int'(nd)) afrm[i+1] = dsel[i];
    if (par_en) afrm[nd+4'd1] = par_bit;
    alen = 4'd2 + nd + {3'b000, par_en} + {3'b000, stop2};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      buf_full <= 1'b0;
      sync_f   <= 1'b0;
      r        <= 1'b1;
      hold     <= '0;
      sh       <= '1;
      cnt      <= '0;
      ext_s    <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_clk};
      if (!legal) begin
        active   <= 1'b0;
        buf_full <= 1'b0;
        r        <= 1'b1;
      end else begin
        if (start) begin
          sh       <= is_sync ? {5'h1F, dsel[7:0]} : afrm;
          cnt      <= is_sync ? 4'd8 : alen;
          active   <= 1'b1;
          sync_f   <= is_sync;
          buf_full <= 1'b0;
        end else if (step_a) begin
          if (end_a) active <= 1'b0;
          else begin
            sh  <= {1'b1, sh[FW-1:1]};
            cnt <= cnt - 4'd1;
          end
        end else if (active && sync_f) begin
          if (drv) sh <= {1'b1, sh[FW-1:1]};
          if (smp) begin
            cnt <= cnt - 4'd1;
            if (cnt == 4'd1) active <= 1'b0;
          end
        end
        if (clk_ext) r <= 1'b1;
        else if (bit_tick && ((start && is_sync) || (active && sync_f))) r <= ~r;
        if (wr_en) begin
          hold     <= wr_data;
          buf_full <= 1'b1;
        end
      end
    end
  end

  assign txd      = inv_line ^ (active ? sh[0] : 1'b1);
  assign sclk_out = r ^ clk_pol;
  assign tx_empty = !active && !buf_full;
endmodule

// File: rtl/sio_tx_chk.sv
module sio_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       inv_line,
  input logic       flow_off,
  input logic       rts_sel,
  input logic       cts_n,
  input logic       wr_en,
  input logic       txd,
  input logic       tx_empty,
  input logic       active
);
  wire legal = (mode == 3'b001) || (mode == 3'b100) || (mode == 3'b101) || (mode == 3'b110);

  // R2
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd == !inv_line);

  // R1
  illegal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> tx_empty);

  // R11
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && !$past(flow_off) && !$past(rts_sel)) |-> !$past(cts_n));

  // R6
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && $past(mode[2])) |-> txd == inv_line);

  // R5
  stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active) && $past(mode[2]) && $past(legal)) |-> $past(txd) != $past(inv_line));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(legal)) |-> !tx_empty);
endmodule

bind sio_tx sio_tx_chk chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .inv_line(inv_line),
  .flow_off(flow_off), .rts_sel(rts_sel), .cts_n(cts_n), .wr_en(wr_en),
  .txd(txd), .tx_empty(tx_empty), .active(active)
);

// File: tb/sio_tx_test.sv
module sio_tx_test;
  logic clk = 0, rst_n = 0, bit_tick = 0;
  logic [2:0] mode = 0;
  logic stop2 = 0, par_en = 0, par_even = 0, inv_line = 0, clk_ext = 0, clk_pol = 0;
  logic msb_first = 0, flow_off = 1, rts_sel = 0, cts_n = 1, ext_clk = 1, wr_en = 0;
  logic [8:0] wr_data = 0;
  logic txd, sclk_out, tx_empty;
  int checks = 0, errors = 0;
  bit done = 0;
  logic exp_bits [0:12];
  int exp_len;

  always #5 clk = ~clk;

  sio_tx uut (.*);

  task automatic chk(input logic [8:0] act, input logic [8:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) bit_tick = 1;
    @(negedge clk) bit_tick = 0;
  endtask

  task automatic do_write(input logic [8:0] d);
    @(negedge clk) begin wr_en = 1; wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask

  function automatic void build(input logic [8:0] d);
    int nd = (mode == 3'b100) ? 7 : (mode == 3'b101) ? 8 : 9;
    int k = 1, ones = 0;
    logic b;
    exp_bits[0] = 0;
    for (int j = 0; j < nd; j++) begin
      b = (mode == 3'b101 && msb_first) ? d[7-j] : d[j];
      ones += int'(b);
      exp_bits[k] = b; k++;
    end
    if (par_en) begin exp_bits[k] = par_even ? ones[0] : ~ones[0]; k++; end
    exp_bits[k] = 1; k++;
    if (stop2) begin exp_bits[k] = 1; k++; end
    exp_len = k;
  endfunction

  // bits of an async frame from index first; R2 R3 R4 R5 R6 R7 R13
  task automatic run_async(input logic [8:0] d, input bit wr, input int first, input bit fin);
    if (wr) begin do_write(d); chk(tx_empty, 0, "R10 busy after write"); end
    build(d);
    for (int i = first; i < exp_len; i++) begin
      pulse_tick();
      chk(txd, exp_bits[i] ^ inv_line, "R2 R3 R4 R5 R6 R7 R13 frame bit");
    end
    if (fin) begin
      pulse_tick();
      chk(tx_empty, 1, "R10 empty after frame");
      chk(txd, !inv_line, "R2 R6 idle level");
    end
  endtask

  // R7 R8 internal synchronous clock
  task automatic run_sync_int(input logic [8:0] d);
    do_write(d);
    for (int k = 0; k < 8; k++) begin
      pulse_tick();
      chk(txd, (msb_first ? d[7-k] : d[k]) ^ inv_line, "R7 R8 sync data");
      chk(sclk_out, clk_pol, "R8 active clock level");
      pulse_tick();
      chk(sclk_out, !clk_pol, "R8 idle clock level");
    end
    chk(tx_empty, 1, "R8 R10 sync frame end");
  endtask

  // R9 external synchronous clock
  task automatic run_sync_ext(input logic [8:0] d);
    @(negedge clk) ext_clk = !clk_pol;
    repeat (5) @(negedge clk);
    do_write(d);
    for (int k = 0; k < 8; k++) begin
      ext_clk = clk_pol;
      repeat (5) @(negedge clk);
      chk(txd, (msb_first ? d[7-k] : d[k]) ^ inv_line, "R9 ext data");
      chk(sclk_out, !clk_pol, "R9 sclk idle");
      ext_clk = !clk_pol;
      repeat (5) @(negedge clk);
    end
    chk(tx_empty, 1, "R9 R10 ext frame end");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [8:0] a, b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(tx_empty, 1, "R10 reset empty");
    chk(txd, 1, "R2 reset idle");
    rst_n = 1;
    @(negedge clk);

    // R1 illegal and disabled codes
    foreach (b[i]) ;
    for (int m = 0; m < 8; m++) begin
      if (m == 1 || m == 4 || m == 5 || m == 6) continue;
      mode = 3'(m);
      do_write(9'h0A5);
      pulse_tick(); pulse_tick();
      chk(tx_empty, 1, "R1 illegal mode stays empty");
      chk(txd, 1, "R1 illegal mode idle line");
    end

    // directed async formats
    mode = 3'b101; run_async(9'h0B6, 1, 0, 1);
    par_en = 1; par_even = 0; run_async(9'h013, 1, 0, 1);
    par_even = 1; stop2 = 1; run_async(9'h013, 1, 0, 1);
    msb_first = 1; run_async(9'h0C1, 1, 0, 1);
    mode = 3'b100; run_async(9'h1FF, 1, 0, 1);
    mode = 3'b110; inv_line = 1; run_async(9'h155, 1, 0, 1);
    inv_line = 0; msb_first = 0; par_en = 0; stop2 = 0;

    // R11 clear-to-send gating
    mode = 3'b101; flow_off = 0; rts_sel = 0; cts_n = 1;
    do_write(9'h03C);
    pulse_tick(); pulse_tick(); pulse_tick();
    chk(txd, 1, "R11 held by cts");
    chk(tx_empty, 0, "R11 word still buffered");
    cts_n = 0;
    run_async(9'h03C, 0, 0, 1);
    rts_sel = 1; cts_n = 1;
    run_async(9'h0E7, 1, 0, 1);
    flow_off = 1; rts_sel = 0;

    // R12 back-to-back
    a = 9'h05A; b = 9'h0A3; par_en = 1;
    do_write(a);
    pulse_tick();
    chk(txd, 0, "R12 first start bit");
    do_write(b);
    build(a);
    for (int i = 1; i < exp_len; i++) begin
      pulse_tick();
      chk(txd, exp_bits[i], "R12 first frame bit");
    end
    pulse_tick();
    chk(txd, 0, "R12 second start with no idle gap");
    chk(tx_empty, 0, "R12 R10 still busy");
    run_async(b, 0, 1, 1);
    par_en = 0;

    // directed synchronous
    mode = 3'b001; clk_pol = 0; run_sync_int(9'h0A1);
    clk_pol = 1; msb_first = 1; run_sync_int(9'h0A1);
    clk_ext = 1; clk_pol = 0; run_sync_ext(9'h036);
    clk_pol = 1; msb_first = 0; run_sync_ext(9'h0C9);
    clk_ext = 0; clk_pol = 0;

    // random mix
    for (int n = 0; n < 60; n++) begin
      int sel = $urandom_range(0, 4);
      stop2 = 1'($urandom); par_en = 1'($urandom); par_even = 1'($urandom);
      inv_line = 1'($urandom); msb_first = 1'($urandom);
      a = 9'($urandom);
      if (sel < 3) begin
        mode = (sel == 0) ? 3'b100 : (sel == 1) ? 3'b101 : 3'b110;
        run_async(a, 1, 0, 1);
      end else begin
        mode = 3'b001; clk_pol = 1'($urandom);
        if (sel == 3) begin clk_ext = 0; run_sync_int(a); end
        else begin clk_ext = 1; run_sync_ext(a); clk_ext = 0; end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule